// File: doc/BRIEF.md
# System Control Port Register File

A byte-wide register file on a simple I/O bus that gathers a board's system control ports in one place. A single port outside the main window drives the processor hard-reset line. Inside a small window of I/O addresses sit four fixed identification and feature bytes, a cache-status byte, a status-light bit, a 4-bit system control field and a one-bit map-type selector. The map-type selector is exported so that an address translator elsewhere can switch between a contiguous and a non-contiguous I/O map.

Two write-only strobes each ask an external non-volatile memory to toggle its lock, through a one-cycle pulse. Reads of addresses that hold no register return all ones. A write to an unassigned address inside the window is dropped and flagged for one cycle. A bus master issues `io_rd` or `io_wr` for one cycle. Read data appears registered on `io_rdata` after that edge and holds until the next read.

Top module: `sysctl_regfile`

## Requirements
- R1: A write to address 0x0092 sets `cpu_hreset` to data bit 0 at the clock edge that samples the write (1 raises it, 0 lowers it). A read of 0x0092 returns {7'b0, cpu_hreset}.
- R2: A read is sampled at a clock edge, and `io_rdata` shows the result from that edge on. `io_rdata` keeps its value on cycles without `io_rd`.
- R3: Reads return 0xEF at 0x0800 (processor configuration), 0xAD at 0x0802 (base features), 0xE0 at 0x0803 (base status) and 0x39 at 0x080C (extended features). Writes to these four change no output and no read value, and raise no error flag.
- R4: A write to 0x0808 sets the light bit from data bit 0. `light_on` shows it, and a read of 0x0808 returns {7'b0, light}.
- R5: A write to 0x081C keeps only data bits 3:0. A read returns those bits with bits 7:4 zero.
- R6: A write to 0x0850 keeps only data bit 0, which drives `map_mode` (0 = contiguous, 1 = non-contiguous). A read returns {7'b0, map_mode}.
- R7: A read of 0x081D returns 0x03, meaning no L2 cache is fitted. A write there is ignored and raises no error flag.
- R8: A write to 0x0810 pulses `nvlock_toggle[0]` high for exactly one cycle. A write to 0x0812 does the same on `nvlock_toggle[1]`. The data value makes no difference.
- R9: Inside 0x0800..0x0851, a read of an address with no register returns 0xFF. A write to such an address changes no state and pulses `bad_wr` high for one cycle. Outside the window, other than 0x0092, reads return 0xFF and writes neither change state nor raise `bad_wr`.
- R10: After reset, `cpu_hreset`, `light_on`, `map_mode`, the control field, `nvlock_toggle` and `bad_wr` are all 0, and `io_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| io_addr | input | ADDR_W (16) | I/O address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data |
| cpu_hreset | output | 1 | Processor hard-reset level |
| light_on | output | 1 | Status-light bit |
| map_mode | output | 1 | I/O map type for the address translator |
| nvlock_toggle | output | 2 | Lock toggle pulses; bit 0 is lock 1, bit 1 is lock 2 |
| bad_wr | output | 1 | One-cycle flag for a write to an unassigned window address |

## Verification
Every result is due one clock edge after its stimulus. This covers read data, level outputs such as `cpu_hreset`, `light_on` and `map_mode`, and the `nvlock_toggle` and `bad_wr` pulses. Each bench task drives the strobe on a falling edge and samples on the next falling edge, which comes just after the edge that registers the result. The pulses are checked a second time one edge later to show that they have dropped. Ignored writes are confirmed by reading back every value they could have touched and watching the output pins.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  // Address map
  localparam int RST_PORT   = 'h0092;
  localparam int WIN_LO     = 'h0800;
  localparam int WIN_HI     = 'h0851;
  localparam int OFF_W      = 7;

  localparam int OFF_CPUCFG = 'h00;
  localparam int OFF_FEAT   = 'h02;
  localparam int OFF_STAT   = 'h03;
  localparam int OFF_LIGHT  = 'h08;
  localparam int OFF_XFEAT  = 'h0C;
  localparam int OFF_LOCK1  = 'h10;
  localparam int OFF_LOCK2  = 'h12;
  localparam int OFF_CTRL   = 'h1C;
  localparam int OFF_L2     = 'h1D;
  localparam int OFF_MAP    = 'h50;

  // Fixed read values
  localparam logic [7:0] VAL_CPUCFG = 8'hEF;
  localparam logic [7:0] VAL_FEAT   = 8'hAD;
  localparam logic [7:0] VAL_STAT   = 8'hE0;
  localparam logic [7:0] VAL_XFEAT  = 8'h39;
  localparam logic [7:0] VAL_L2     = 8'h03;
  localparam logic [7:0] VAL_EMPTY  = 8'hFF;

  localparam int CTRL_W = 4;
  localparam int LOCK_N = 2;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_RST, SEL_CPUCFG, SEL_FEAT, SEL_STAT, SEL_XFEAT,
    SEL_LIGHT, SEL_LOCK1, SEL_LOCK2, SEL_CTRL, SEL_L2, SEL_MAP,
    SEL_HOLE
  } reg_sel_e;

  // Offset inside the window to register selector
  function automatic reg_sel_e offset_sel(input logic [OFF_W-1:0] off);
    case (int'(off))
      OFF_CPUCFG: return SEL_CPUCFG;
      OFF_FEAT:   return SEL_FEAT;
      OFF_STAT:   return SEL_STAT;
      OFF_XFEAT:  return SEL_XFEAT;
      OFF_LIGHT:  return SEL_LIGHT;
      OFF_LOCK1:  return SEL_LOCK1;
      OFF_LOCK2:  return SEL_LOCK2;
      OFF_CTRL:   return SEL_CTRL;
      OFF_L2:     return SEL_L2;
      OFF_MAP:    return SEL_MAP;
      default:    return SEL_HOLE;
    endcase
  endfunction

  // Selector that fires lock strobe number idx
  function automatic reg_sel_e lock_sel(input int idx);
    return (idx == 0) ? SEL_LOCK1 : SEL_LOCK2;
  endfunction

  // Field extraction on write
  function automatic logic [CTRL_W-1:0] ctrl_field(input logic [7:0] d);
    return d[CTRL_W-1:0];
  endfunction

  function automatic logic [7:0] bit_byte(input logic b);
    return {7'b0, b};
  endfunction

  function automatic logic [7:0] ctrl_byte(input logic [CTRL_W-1:0] c);
    return {{(8-CTRL_W){1'b0}}, c};
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam logic [ADDR_W-1:0] A_RST = ADDR_W'(RST_PORT);
  localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(WIN_LO);
  localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(WIN_HI);

  logic              in_win;
  logic [ADDR_W-1:0] off;

  assign in_win = (addr >= A_LO) && (addr <= A_HI);
  assign off    = addr - A_LO;

  always_comb begin
    if (addr == A_RST)  sel = SEL_RST;
    else if (in_win)    sel = offset_sel(off[OFF_W-1:0]);
    else                sel = SEL_NONE;
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  reg_sel_e          sel,
  input  logic [7:0]        wdata,
  output logic              hreset_q,
  output logic              light_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              map_q,
  output logic [LOCK_N-1:0] lock_q,
  output logic              bad_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hreset_q <= 1'b0;
      light_q  <= 1'b0;
      ctrl_q   <= '0;
      map_q    <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      bad_q <= 1'b0;
      if (wr) begin
        case (sel)
          SEL_RST:   hreset_q <= wdata[0];
          SEL_LIGHT: light_q  <= wdata[0];
          SEL_CTRL:  ctrl_q   <= ctrl_field(wdata);
          SEL_MAP:   map_q    <= wdata[0];
          SEL_HOLE:  bad_q    <= 1'b1;
          default:   ;
        endcase
      end
    end
  end

  for (genvar g = 0; g < LOCK_N; g++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q[g] <= 1'b0;
      else        lock_q[g] <= wr && (sel == lock_sel(g));
    end
  end
endmodule

// File: rtl/sysctl_rdmux.sv
module sysctl_rdmux
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  reg_sel_e          sel,
  input  logic              hreset_q,
  input  logic              light_q,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              map_q,
  output logic [7:0]        rdata_q
);
  logic [7:0] rd_val;

  always_comb begin
    case (sel)
      SEL_RST:    rd_val = bit_byte(hreset_q);
      SEL_CPUCFG: rd_val = VAL_CPUCFG;
      SEL_FEAT:   rd_val = VAL_FEAT;
      SEL_STAT:   rd_val = VAL_STAT;
      SEL_XFEAT:  rd_val = VAL_XFEAT;
      SEL_LIGHT:  rd_val = bit_byte(light_q);
      SEL_CTRL:   rd_val = ctrl_byte(ctrl_q);
      SEL_L2:     rd_val = VAL_L2;
      SEL_MAP:    rd_val = bit_byte(map_q);
      default:    rd_val = VAL_EMPTY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= VAL_EMPTY;
    else if (rd) rdata_q <= rd_val;
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cpu_hreset,
  output logic              light_on,
  output logic              map_mode,
  output logic [1:0]        nvlock_toggle,
  output logic              bad_wr
);
  reg_sel_e          sel;
  logic              hreset_q, light_q, map_q, bad_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [LOCK_N-1:0] lock_q;

  sysctl_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (io_addr),
    .sel  (sel)
  );

  sysctl_store u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (io_wr),
    .sel      (sel),
    .wdata    (io_wdata),
    .hreset_q (hreset_q),
    .light_q  (light_q),
    .ctrl_q   (ctrl_q),
    .map_q    (map_q),
    .lock_q   (lock_q),
    .bad_q    (bad_q)
  );

  sysctl_rdmux u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (io_rd),
    .sel      (sel),
    .hreset_q (hreset_q),
    .light_q  (light_q),
    .ctrl_q   (ctrl_q),
    .map_q    (map_q),
    .rdata_q  (io_rdata)
  );

  assign cpu_hreset    = hreset_q;
  assign light_on      = light_q;
  assign map_mode      = map_q;
  assign nvlock_toggle = lock_q;
  assign bad_wr        = bad_q;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cpu_hreset,
  input logic              map_mode,
  input logic [1:0]        nvlock_toggle,
  input logic              bad_wr,
  input reg_sel_e          sel,
  input logic [CTRL_W-1:0] ctrl_q
);
  assert_hreset_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel == SEL_RST) |=> (cpu_hreset == $past(io_wdata[0])));

  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  assert_ctrl_low_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel == SEL_CTRL) |=> (ctrl_q == $past(io_wdata[CTRL_W-1:0])));

  assert_map_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel == SEL_MAP) |=> (map_mode == $past(io_wdata[0])));

  assert_map_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && sel == SEL_MAP) |=> $stable(map_mode));

  assert_l2_value_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && sel == SEL_L2) |=> (io_rdata == 8'h03));

  assert_lock_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (nvlock_toggle != 2'b00) |-> ($past(io_wr) && $onehot(nvlock_toggle)));

  assert_hole_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && (sel == SEL_HOLE || sel == SEL_NONE)) |=> (io_rdata == 8'hFF));

  assert_bad_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && sel == SEL_HOLE) |=> bad_wr);

  assert_bad_only_hole_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_wr && sel == SEL_HOLE) |=> !bad_wr);
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .io_wr         (io_wr),
  .io_rd         (io_rd),
  .io_wdata      (io_wdata),
  .io_rdata      (io_rdata),
  .cpu_hreset    (cpu_hreset),
  .map_mode      (map_mode),
  .nvlock_toggle (nvlock_toggle),
  .bad_wr        (bad_wr),
  .sel           (sel),
  .ctrl_q        (ctrl_q)
);

// File: tb/sysctl_regfile_tb.sv
`timescale 1ns/100ps
module sysctl_regfile_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        cpu_hreset, light_on, map_mode, bad_wr;
  logic [1:0]  nvlock_toggle;

  int checks = 0;
  int errors = 0;
  logic [1:0] lk_now, lk_after;
  logic       bad_now, bad_after;

  always #2.5 clk = ~clk;

  sysctl_regfile u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .cpu_hreset(cpu_hreset),
    .light_on(light_on), .map_mode(map_mode), .nvlock_toggle(nvlock_toggle),
    .bad_wr(bad_wr)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Write: strobe one cycle, capture pulses on the edge after and one later
  task automatic wr_io(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    lk_now = nvlock_toggle; bad_now = bad_wr;
    @(negedge clk);
    lk_after = nvlock_toggle; bad_after = bad_wr;
  endtask

  task automatic rd_io(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic t_reset_state();
    logic [7:0] v;
    check("R10 rdata", int'(io_rdata), 'hFF);
    check("R10 hreset", int'(cpu_hreset), 0);
    check("R10 light", int'(light_on), 0);
    check("R10 map", int'(map_mode), 0);
    check("R10 lock", int'(nvlock_toggle), 0);
    check("R10 bad", int'(bad_wr), 0);
    rd_io(16'h081C, v); check("R10 ctrl", int'(v), 0);
  endtask

  task automatic t_reset_port();
    logic [7:0] v;
    wr_io(16'h0092, 8'h01); check("R1 hreset high", int'(cpu_hreset), 1);
    rd_io(16'h0092, v);     check("R1 readback", int'(v), 1);
    wr_io(16'h0092, 8'hFE); check("R1 hreset low", int'(cpu_hreset), 0);
    check("R1 no bad", int'(bad_now), 0);
  endtask

  task automatic t_id_regs();
    logic [7:0] v;
    rd_io(16'h0800, v); check("R3 cpucfg", int'(v), 'hEF);
    rd_io(16'h0802, v); check("R3 feat", int'(v), 'hAD);
    rd_io(16'h0803, v); check("R3 stat", int'(v), 'hE0);
    rd_io(16'h080C, v); check("R3 xfeat", int'(v), 'h39);
    wr_io(16'h0800, 8'h00); check("R3 write no bad", int'(bad_now), 0);
    wr_io(16'h080C, 8'h55);
    rd_io(16'h0800, v); check("R3 cpucfg after write", int'(v), 'hEF);
    rd_io(16'h080C, v); check("R3 xfeat after write", int'(v), 'h39);
    check("R3 outputs untouched", int'({cpu_hreset, light_on, map_mode}), 0);
  endtask

  task automatic t_light();
    logic [7:0] v;
    wr_io(16'h0808, 8'hF1); check("R4 light on", int'(light_on), 1);
    rd_io(16'h0808, v);     check("R4 readback", int'(v), 1);
    wr_io(16'h0808, 8'h02); check("R4 light off", int'(light_on), 0);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr_io(16'h081C, 8'hA5); rd_io(16'h081C, v); check("R5 ctrl A5", int'(v), 'h05);
    wr_io(16'h081C, 8'h3C); rd_io(16'h081C, v); check("R5 ctrl 3C", int'(v), 'h0C);
  endtask

  task automatic t_map();
    logic [7:0] v;
    wr_io(16'h0850, 8'hFF); check("R6 map set", int'(map_mode), 1);
    rd_io(16'h0850, v);     check("R6 readback", int'(v), 1);
    wr_io(16'h0850, 8'h02); check("R6 map clear", int'(map_mode), 0);
  endtask

  task automatic t_l2();
    logic [7:0] v;
    rd_io(16'h081D, v); check("R7 l2", int'(v), 3);
    wr_io(16'h081D, 8'hFF); check("R7 write no bad", int'(bad_now), 0);
    rd_io(16'h081D, v); check("R7 l2 after write", int'(v), 3);
  endtask

  task automatic t_locks();
    check("R8 idle", int'(nvlock_toggle), 0);
    wr_io(16'h0810, 8'h00);
    check("R8 lock1 pulse", int'(lk_now), 1);
    check("R8 lock1 drop", int'(lk_after), 0);
    wr_io(16'h0812, 8'h77);
    check("R8 lock2 pulse", int'(lk_now), 2);
    check("R8 lock2 drop", int'(lk_after), 0);
  endtask

  task automatic t_holes();
    logic [7:0] v;
    rd_io(16'h0801, v); check("R9 hole read 801", int'(v), 'hFF);
    rd_io(16'h0851, v); check("R9 hole read 851", int'(v), 'hFF);
    rd_io(16'h0900, v); check("R9 outside read", int'(v), 'hFF);
    wr_io(16'h0851, 8'h01);
    check("R9 bad pulse", int'(bad_now), 1);
    check("R9 bad drop", int'(bad_after), 0);
    check("R9 hole write no effect", int'({cpu_hreset, light_on, map_mode, lk_now}), 0);
    wr_io(16'h0900, 8'h01);
    check("R9 outside no bad", int'(bad_now), 0);
    wr_io(16'h0093, 8'h01);
    check("R9 outside no effect", int'({cpu_hreset, light_on, map_mode, bad_now}), 0);
  endtask

  task automatic t_hold();
    logic [7:0] v;
    rd_io(16'h0802, v);
    repeat (3) @(negedge clk);
    check("R2 rdata holds", int'(io_rdata), 'hAD);
    io_addr = 16'h0800;
    @(negedge clk);
    check("R2 no read no change", int'(io_rdata), 'hAD);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_reset_port();
    t_id_regs();
    t_light();
    t_ctrl();
    t_map();
    t_l2();
    t_locks();
    t_holes();
    t_hold();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule